// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that finishes every instruction in one clock cycle. It fetches a 32-bit instruction word at the program counter. It reads two operands from a 32-entry register file and computes a result or an address in an arithmetic unit. It then writes back to the register file or to data memory, and chooses the next program counter from three sources: the sequential address, a branch target or a jump target. Nine instructions are supported: word load and store, add, subtract, bitwise AND and OR, signed set-on-less-than, branch when equal, and an absolute jump.

The instruction and data stores are small word arrays inside the core. They are written on the clock edge and read without a clock. While reset is held, a pair of preload ports fills them, so a test harness can place a program and its data before execution starts. Each clock, the core exposes the program counter and the register-file and data-memory write strobes with their address and data. This lets an observer follow the architectural state cycle by cycle.

Top module: `rscCore`

## Requirements
- R1: With opcode 0 (bits 31:26), the register selected by bits 15:11 receives the result of the operation chosen by bits 5:0. The codes are 32 add, 34 subtract, 36 AND, 37 OR, and 42 signed less-than, which yields 1 or 0. The operands are the registers named by bits 25:21 and 20:16.
- R2: With opcode 35, the register named by bits 20:16 receives the data word at the address formed as (register of bits 25:21) plus the sign-extended bits 15:0.
- R3: With opcode 43, the data word at that same address takes the value of the register named by bits 20:16, and no register write is strobed.
- R4: With opcode 4, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2 when the two source registers are equal, and PC+4 otherwise. No write is strobed.
- R5: With opcode 2, the next PC is bits 31:28 of PC+4, followed by bits 25:0, followed by two zero bits. No write is strobed.
- R6: Register 0 always reads as zero, and any write addressed to it is discarded.
- R7: A synchronous reset sets the PC to 0, clears the registers, and holds both write strobes low while it is asserted.
- R8: Any other opcode advances the PC by 4 and strobes no write.
- R9: The preload ports change the instruction or data store only while reset is asserted. When reset is low, they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ldImemEn | input | 1 | Instruction-store preload write enable (honoured only in reset) |
| ldImemAddr | input | IAW | Instruction-store preload word index |
| ldImemData | input | 32 | Instruction-store preload word |
| ldDmemEn | input | 1 | Data-store preload write enable (honoured only in reset) |
| ldDmemAddr | input | DAW | Data-store preload word index |
| ldDmemData | input | 32 | Data-store preload word |
| pcOut | output | 32 | Current program counter |
| rfWe | output | 1 | Register-file write strobe for the current instruction |
| rfWaddr | output | 5 | Register-file write index |
| rfWdata | output | 32 | Register-file write data |
| dmWe | output | 1 | Data-store write strobe |
| dmAddr | output | 32 | Data-store byte address (arithmetic unit result) |
| dmWdata | output | 32 | Data-store write data |

## Verification
The bench builds the core with 64-word instruction and data stores. This holds a program that uses every opcode, an unknown opcode, a forward taken branch, an untaken branch, a jump over a word, and a branch-to-self loop that ends the run. The data store is large enough that a negative load/store offset from a base register lands on a word that is loaded back later. A second reset in mid-run brings in a run that starts from cleared registers but keeps the data stored earlier. Preload writes attempted while running target a word that is executed afterwards and a word that is loaded afterwards.

// File: rtl/rscPkg.sv
package rscPkg;
  localparam int XLEN = 32;
  localparam int REGS = 32;
  localparam int RAW  = $clog2(REGS);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_J     = 6'd2;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } aluFn_e;

  typedef struct packed {
    logic       regWrite;
    logic       regDst;
    logic       aluSrc;
    logic       memWrite;
    logic       memToReg;
    logic       branch;
    logic       jump;
    logic [1:0] aluOp;
  } ctlStrobes_t;
endpackage

// File: rtl/rscControl.sv
module rscControl
  import rscPkg::*;
(
  input  logic        rst,
  input  logic [5:0]  opcode,
  output ctlStrobes_t ctl
);
  always_comb begin
    ctl = '0;
    if (!rst) begin
      case (opcode)
        OP_RTYPE: begin
          ctl.regWrite = 1'b1;
          ctl.regDst   = 1'b1;
          ctl.aluOp    = 2'b10;
        end
        OP_LW: begin
          ctl.regWrite = 1'b1;
          ctl.aluSrc   = 1'b1;
          ctl.memToReg = 1'b1;
        end
        OP_SW: begin
          ctl.aluSrc   = 1'b1;
          ctl.memWrite = 1'b1;
        end
        OP_BEQ: begin
          ctl.branch = 1'b1;
          ctl.aluOp  = 2'b01;
        end
        OP_J: ctl.jump = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rscAluCtl.sv
module rscAluCtl
  import rscPkg::*;
(
  input  logic [1:0] aluOp,
  input  logic [5:0] funct,
  output aluFn_e     fn
);
  always_comb begin
    case (aluOp)
      2'b00: fn = ALU_ADD;
      2'b01: fn = ALU_SUB;
      default: begin
        case (funct)
          FN_ADD:  fn = ALU_ADD;
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_AND;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/rscDatapath.sv
module rscDatapath
  import rscPkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctlStrobes_t     ctl,
  input  aluFn_e          fn,
  input  logic            ldImemEn,
  input  logic [IAW-1:0]  ldImemAddr,
  input  logic [XLEN-1:0] ldImemData,
  input  logic            ldDmemEn,
  input  logic [DAW-1:0]  ldDmemAddr,
  input  logic [XLEN-1:0] ldDmemData,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic [XLEN-1:0] pcOut,
  output logic            rfWe,
  output logic [RAW-1:0]  rfWaddr,
  output logic [XLEN-1:0] rfWdata,
  output logic            dmWe,
  output logic [XLEN-1:0] dmAddr,
  output logic [XLEN-1:0] dmWdata
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] regs [REGS];

  logic [XLEN-1:0] pc, pcPlus4, pcNext, instr, immExt, branchTgt, jumpTgt;
  logic [XLEN-1:0] rsVal, rtVal, opB, aluRes, dmRdata, wbData;
  logic [RAW-1:0]  rsIdx, rtIdx, rdIdx, wIdx;
  logic            zero;

  assign instr  = imem[pc[2 +: IAW]];
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};

  // register file: entry 0 is a constant zero, the rest are generated
  assign regs[0] = '0;
  for (genvar g = 1; g < REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (ctl.regWrite && wIdx == RAW'(g))
        regs[g] <= wbData;
    end
  end

  assign rsVal = regs[rsIdx];
  assign rtVal = regs[rtIdx];
  assign wIdx  = ctl.regDst ? rdIdx : rtIdx;

  assign opB = ctl.aluSrc ? immExt : rtVal;
  always_comb begin
    case (fn)
      ALU_AND: aluRes = rsVal & opB;
      ALU_OR:  aluRes = rsVal | opB;
      ALU_ADD: aluRes = rsVal + opB;
      ALU_SUB: aluRes = rsVal - opB;
      ALU_SLT: aluRes = {{(XLEN-1){1'b0}}, $signed(rsVal) < $signed(opB)};
      default: aluRes = '0;
    endcase
  end
  assign zero = (aluRes == '0);

  assign dmRdata = dmem[aluRes[2 +: DAW]];
  assign wbData  = ctl.memToReg ? dmRdata : aluRes;

  always_ff @(posedge clk) begin
    if (rst ? ldDmemEn : ctl.memWrite)
      dmem[rst ? ldDmemAddr : aluRes[2 +: DAW]] <= rst ? ldDmemData : rtVal;
  end

  always_ff @(posedge clk) begin
    if (rst && ldImemEn)
      imem[ldImemAddr] <= ldImemData;
  end

  assign pcPlus4   = pc + XLEN'(4);
  assign branchTgt = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jumpTgt   = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign pcNext    = ctl.jump ? jumpTgt :
                     (ctl.branch && zero) ? branchTgt : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut   = pc;
  assign rfWe    = ctl.regWrite;
  assign rfWaddr = wIdx;
  assign rfWdata = wbData;
  assign dmWe    = ctl.memWrite;
  assign dmAddr  = aluRes;
  assign dmWdata = rtVal;
endmodule

// File: rtl/rscCore.sv
module rscCore
  import rscPkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ldImemEn,
  input  logic [IAW-1:0]  ldImemAddr,
  input  logic [31:0]     ldImemData,
  input  logic            ldDmemEn,
  input  logic [DAW-1:0]  ldDmemAddr,
  input  logic [31:0]     ldDmemData,
  output logic [31:0]     pcOut,
  output logic            rfWe,
  output logic [4:0]      rfWaddr,
  output logic [31:0]     rfWdata,
  output logic            dmWe,
  output logic [31:0]     dmAddr,
  output logic [31:0]     dmWdata
);
  ctlStrobes_t ctlW;
  aluFn_e      fnW;
  logic [5:0]  opcodeW, functW;

  rscControl u_ctl (
    .rst(rst), .opcode(opcodeW), .ctl(ctlW)
  );

  rscAluCtl u_aluCtl (
    .aluOp(ctlW.aluOp), .funct(functW), .fn(fnW)
  );

  rscDatapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctlW), .fn(fnW),
    .ldImemEn(ldImemEn), .ldImemAddr(ldImemAddr), .ldImemData(ldImemData),
    .ldDmemEn(ldDmemEn), .ldDmemAddr(ldDmemAddr), .ldDmemData(ldDmemData),
    .opcode(opcodeW), .funct(functW), .pcOut(pcOut),
    .rfWe(rfWe), .rfWaddr(rfWaddr), .rfWdata(rfWdata),
    .dmWe(dmWe), .dmAddr(dmAddr), .dmWdata(dmWdata)
  );
endmodule

// File: rtl/rscCoreChk.sv
module rscCoreChk (
  input logic        clk,
  input logic        rst,
  input logic [5:0]  opcode,
  input logic [31:0] pcOut,
  input logic        rfWe,
  input logic        dmWe
);
  logic known;
  assign known = (opcode == 6'd0) || (opcode == 6'd35) || (opcode == 6'd43) ||
                 (opcode == 6'd4) || (opcode == 6'd2);

  a_r7_reset_pc: assert property (@(posedge clk) rst |=> pcOut == 32'd0);

  a_r7_quiet_in_reset: assert property (@(posedge clk) rst |-> (!rfWe && !dmWe));

  a_r8_sequential_pc: assert property (@(posedge clk) disable iff (rst)
    (opcode != 6'd4 && opcode != 6'd2) |=> pcOut == $past(pcOut) + 32'd4);

  a_r8_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!rfWe && !dmWe));

  a_r3_store_strobes: assert property (@(posedge clk) disable iff (rst)
    opcode == 6'd43 |-> (dmWe && !rfWe));

  a_r4_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    opcode == 6'd4 |-> (!rfWe && !dmWe));

  a_r5_jump_aligned: assert property (@(posedge clk) disable iff (rst)
    opcode == 6'd2 |=> pcOut[1:0] == 2'b00);
endmodule

bind rscCore rscCoreChk u_chk (
  .clk(clk), .rst(rst), .opcode(opcodeW), .pcOut(pcOut),
  .rfWe(rfWe), .dmWe(dmWe)
);

// File: tb/sim_rscCore.sv
`timescale 1ns/1ps
module sim_rscCore;
  logic        clk = 1'b0;
  logic        rst;
  logic        ldImemEn, ldDmemEn;
  logic [5:0]  ldImemAddr, ldDmemAddr;
  logic [31:0] ldImemData, ldDmemData;
  logic [31:0] pcOut, rfWdata, dmAddr, dmWdata;
  logic        rfWe, dmWe;
  logic [4:0]  rfWaddr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  rscCore #(.IMEM_WORDS(64), .DMEM_WORDS(64)) u0 (
    .clk(clk), .rst(rst),
    .ldImemEn(ldImemEn), .ldImemAddr(ldImemAddr), .ldImemData(ldImemData),
    .ldDmemEn(ldDmemEn), .ldDmemAddr(ldDmemAddr), .ldDmemData(ldDmemData),
    .pcOut(pcOut), .rfWe(rfWe), .rfWaddr(rfWaddr), .rfWdata(rfWdata),
    .dmWe(dmWe), .dmAddr(dmAddr), .dmWdata(dmWdata)
  );

  // behavioural reference state
  logic [31:0] mImem [64];
  logic [31:0] mDmem [64];
  logic [31:0] mReg  [32];
  logic [31:0] mPc;

  function automatic logic [31:0] encR(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPc = 0;
    for (int i = 0; i < 32; i++) mReg[i] = 0;
  endtask

  // compare one cycle of DUT outputs with the model, then advance the model
  task automatic stepAndCheck();
    logic [31:0] ins, a, b, imm, res, nextPc, eData;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    bit          eWe, eDm;
    int          eAddr;
    string       tag;
    ins = mImem[mPc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    imm = {{16{ins[15]}}, ins[15:0]};
    a = mReg[rs]; b = mReg[rt];
    nextPc = mPc + 4; eWe = 0; eDm = 0; eAddr = 0; eData = 0; res = 0;
    case (op)
      6'd0: begin
        tag = "R1";
        case (fn)
          6'd32: res = a + b;
          6'd34: res = a - b;
          6'd36: res = a & b;
          6'd37: res = a | b;
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = 0;
        endcase
        eWe = 1; eAddr = rd; eData = res;
        if (rd == 0 || rs == 0 || rt == 0) tag = "R6";
      end
      6'd35: begin
        tag = "R2";
        res = a + imm;
        eWe = 1; eAddr = rt; eData = mDmem[res[7:2]];
      end
      6'd43: begin
        tag = "R3";
        res = a + imm; eDm = 1;
      end
      6'd4: begin
        tag = "R4";
        if (a == b) nextPc = mPc + 4 + (imm << 2);
      end
      6'd2: begin
        tag = "R5";
        nextPc = {mPc[31:28] + ((mPc + 4) >> 28) - mPc[31:28], ins[25:0], 2'b00};
        nextPc[31:28] = (mPc + 32'd4) >> 28;
      end
      default: tag = "R8";
    endcase
    if (mPc == 32'd76 || mPc == 32'd80) tag = "R9";
    chk(tag, "pc", pcOut, mPc);
    chk(tag, "rfWe", {31'd0, rfWe}, {31'd0, eWe});
    if (eWe) begin
      chk(tag, "rfWaddr", {27'd0, rfWaddr}, 32'(eAddr));
      chk(tag, "rfWdata", rfWdata, eData);
    end
    chk(tag, "dmWe", {31'd0, dmWe}, {31'd0, eDm});
    if (eDm) begin
      chk(tag, "dmAddr", dmAddr, res);
      chk(tag, "dmWdata", dmWdata, b);
    end
    if (eWe && eAddr != 0) mReg[eAddr] = eData;
    if (eDm) mDmem[res[7:2]] = b;
    mPc = nextPc;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1; ldImemEn = 0; ldDmemEn = 0;
    ldImemAddr = 0; ldDmemAddr = 0; ldImemData = 0; ldDmemData = 0;
    for (int i = 0; i < 64; i++) begin mImem[i] = 0; mDmem[i] = 0; end
    mImem[0]  = encI(35, 0, 1, 16'd0);
    mImem[1]  = encI(35, 0, 2, 16'd4);
    mImem[2]  = encR(1, 2, 3, 32);
    mImem[3]  = encR(1, 2, 4, 34);
    mImem[4]  = encR(1, 2, 5, 36);
    mImem[5]  = encR(1, 2, 6, 37);
    mImem[6]  = encR(2, 1, 7, 42);
    mImem[7]  = encR(1, 2, 8, 42);
    mImem[8]  = encR(1, 1, 0, 32);
    mImem[9]  = encR(0, 1, 9, 32);
    mImem[10] = encI(35, 0, 12, 16'd12);
    mImem[11] = encI(43, 12, 4, 16'hFFF8);
    mImem[12] = encI(35, 0, 13, 16'd12);
    mImem[13] = encI(4, 1, 2, 16'd5);
    mImem[14] = encI(4, 3, 3, 16'd1);
    mImem[15] = encR(1, 1, 14, 32);
    mImem[16] = encI(8, 1, 1, 16'd7);
    mImem[17] = {6'd2, 26'd19};
    mImem[18] = encR(1, 1, 14, 32);
    mImem[19] = encI(35, 0, 15, 16'd0);
    mImem[20] = encI(43, 0, 15, 16'd16);
    mImem[21] = encI(4, 0, 0, 16'hFFFF);
    mDmem[0] = 32'd5; mDmem[1] = 32'hFFFF_FFFD; mDmem[2] = 32'd0; mDmem[3] = 32'd20;

    repeat (2) @(negedge clk);
    for (int i = 0; i < 22; i++) begin
      ldImemEn = 1; ldImemAddr = 6'(i); ldImemData = mImem[i];
      ldDmemEn = (i < 4); ldDmemAddr = 6'(i); ldDmemData = mDmem[i];
      @(negedge clk);
    end
    ldImemEn = 0; ldDmemEn = 0;
    @(negedge clk);
    #1;
    chk("R7", "reset pc", pcOut, 32'd0);
    chk("R7", "reset rfWe", {31'd0, rfWe}, 32'd0);
    chk("R7", "reset dmWe", {31'd0, dmWe}, 32'd0);
    modelReset();

    @(negedge clk);
    rst = 0;
    for (int c = 0; c < 30; c++) begin
      if (c == 2) begin
        // R9: preload attempts while running must be ignored
        ldImemEn = 1; ldImemAddr = 6'd20; ldImemData = encR(1, 1, 14, 32);
        ldDmemEn = 1; ldDmemAddr = 6'd0;  ldDmemData = 32'd77;
      end else begin
        ldImemEn = 0; ldDmemEn = 0;
      end
      #1;
      stepAndCheck();
      @(negedge clk);
    end

    rst = 1;
    @(negedge clk);
    #1;
    chk("R7", "mid-run reset pc", pcOut, 32'd0);
    chk("R7", "mid-run reset rfWe", {31'd0, rfWe}, 32'd0);
    chk("R7", "mid-run reset dmWe", {31'd0, dmWe}, 32'd0);
    modelReset();
    @(negedge clk);
    rst = 0;
    for (int c = 0; c < 25; c++) begin
      #1;
      stepAndCheck();
      @(negedge clk);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule